// File: doc/BRIEF.md
# Multi-Phase Fault and Freeze Manager

This block is the supervisory fault logic for one half-bridge gate driver. It joins a group of peer drivers over two shared active-low lines. Each line is open-drain and wired-OR. The first is a fault/shutdown line that a host controller can also see and pull. The second is a sync-fault line local to the drivers. The block takes in the following:

- desaturation requests and soft-shutdown-active flags for both channels;
- the logic-supply and floating-supply undervoltage flags;
- a fault-clear input;
- the high-side command.

From these it produces:

- pull-down enables for the two shared lines;
- a hard-shutdown signal for both channels;
- a freeze (hold) signal for the input stage;
- a high-side block signal.

The core is a Moore state machine with six states:

- `ST_NORMAL`: nothing active.
- `ST_FREEZE`: a peer holds the sync line low.
- `ST_SHUTDOWN`: the fault/shutdown line is seen low without a local cause.
- `ST_UVLO`: the logic supply is low.
- `ST_SOFT`: a local soft shutdown is in progress.
- `ST_LATCH`: a desaturation fault is latched.

The four open states (`ST_NORMAL`, `ST_FREEZE`, `ST_SHUTDOWN`, `ST_UVLO`) re-evaluate each cycle in a fixed priority order:

1. desaturation or soft shutdown moves to `ST_SOFT`;
2. undervoltage moves to `ST_UVLO`;
3. a low fault line moves to `ST_SHUTDOWN`;
4. a low sync line moves to `ST_FREEZE`;
5. otherwise the state is `ST_NORMAL`.

The other two states have fixed exits. `ST_SOFT` moves to `ST_LATCH` once no request or flag remains. `ST_LATCH` moves to `ST_SHUTDOWN` on an accepted clear.

Both shared line values pass through a two-stage synchronizer before the state machine sees them. A separate gate latches the high side off during floating-supply undervoltage.

Top module: `phase_fault_mgr`

## Requirements
- R1: A desaturation request or soft-shutdown flag on either side moves the block to soft shutdown on the next clock edge. There it drives the sync line pull-down (`sync_line_pd`=1) and `freeze`=1, keeps `hard_shdn`=0, and keeps `fault_line_pd`=0.
- R2: While soft shutdown lasts, logic-supply undervoltage and a low fault/shutdown line have no effect on any output. Soft shutdown lasts as long as any soft-shutdown flag or desaturation request is high.
- R3: On the first edge with no flag or request left, soft shutdown ends in the latched fault state. That state has `fault_line_pd`=1, `hard_shdn`=1 and `sync_line_pd`=0, and it holds until an accepted fault clear.
- R4: Fault clear (`flt_clr`=1) is ignored while the synchronized sync line is low. An accepted clear drops `fault_line_pd` on the next edge. `hard_shdn` stays 1 until the synchronized fault line reads high, which is three edges after the clear.
- R5: Logic-supply undervoltage (`uv_vcc`=1) sets `fault_line_pd`=1 and `hard_shdn`=1 on the next edge and only while it persists. Once it ends, `fault_line_pd` drops on the next edge and `hard_shdn` drops three edges later.
- R6: A fault/shutdown line pulled low externally raises `hard_shdn` three edges after the pull. Fault clear cannot release it. `hard_shdn` drops three edges after the line returns high.
- R7: A sync line pulled low by a peer raises `freeze` three edges later, with `hard_shdn`=0. Among open-state causes, the fault line low overrides the sync line, and undervoltage overrides both.
- R8: A desaturation request during freeze, undervoltage or external shutdown takes priority and enters soft shutdown on the next edge.
- R9: Floating-supply undervoltage (`uv_vbs`=1) sets `hs_off`=1 on the next edge. It does not affect `fault_line_pd`, `sync_line_pd` or `hard_shdn`.
- R10: After `uv_vbs` returns low, `hs_off` stays 1 until an edge where `hin`=1 follows an edge where `hin`=0. A rising `hin` during the undervoltage does not count.
- R11: After reset the block is in the normal state with every output 0, and both synchronizers read the lines as idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desat_hi_req | input | 1 | High-side desaturation request |
| desat_lo_req | input | 1 | Low-side desaturation request |
| ssd_hi_act | input | 1 | High-side soft shutdown in progress |
| ssd_lo_act | input | 1 | Low-side soft shutdown in progress |
| uv_vcc | input | 1 | Logic-supply undervoltage |
| uv_vbs | input | 1 | Floating-supply undervoltage |
| flt_clr | input | 1 | Fault clear, active high |
| hin | input | 1 | High-side command |
| fault_line_in | input | 1 | Sampled level of the shared fault/shutdown line |
| sync_line_in | input | 1 | Sampled level of the shared sync-fault line |
| fault_line_pd | output | 1 | Pull-down enable for the fault/shutdown line |
| sync_line_pd | output | 1 | Pull-down enable for the sync-fault line |
| hard_shdn | output | 1 | Hard shutdown of both channels |
| freeze | output | 1 | Hold both outputs at their previous state |
| hs_off | output | 1 | Force the high side off |

## Verification
The direct inputs (desaturation, soft-shutdown flags, undervoltage, fault clear and `hin`) act on the outputs one edge after they change. The two shared lines pass two synchronizer stages and the state register, so their effect is due three edges later. The bench drives every input on the falling edge and then waits a stated number of rising edges before it samples on a falling edge. For the line cases it checks both sides of the boundary: the value two edges after a line change must be the old one, and the value on the third edge must be the new one. The wired-OR lines are modelled in the bench by combining the block's pull-downs with external pulls, so that the block's own pull-down is read back through the synchronizers just as it would be on a board.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_FREEZE   = 3'd1,
        ST_SHUTDOWN = 3'd2,
        ST_UVLO     = 3'd3,
        ST_SOFT     = 3'd4,
        ST_LATCH    = 3'd5
    } pfm_state_e;

    typedef struct packed {
        logic fault_pd;
        logic sync_pd;
        logic hard_shdn;
        logic freeze;
    } pfm_drive_t;

    localparam int unsigned PFM_SYNC_STAGES = 2;

endpackage

// File: rtl/pfm_line_sync.sv
module pfm_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_hi
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= line_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], line_raw};
            end
        end
    endgenerate

    assign line_hi = chain_q[LAST];

endmodule

// File: rtl/pfm_fault_fsm.sv
module pfm_fault_fsm
    import pfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       desat_any,
    input  logic       ssd_any,
    input  logic       uv_vcc,
    input  logic       flt_clr,
    input  logic       fault_line_hi,
    input  logic       sync_line_hi,
    output pfm_state_e state,
    output pfm_drive_t drv
);

    pfm_state_e st_q, st_d;
    logic       soft_req;
    logic       clr_ok;

    assign soft_req = desat_any | ssd_any;
    assign clr_ok   = flt_clr & sync_line_hi;

    function automatic pfm_state_e open_pick(
        input logic sreq, input logic uv,
        input logic f_hi, input logic s_hi
    );
        if (sreq)       return ST_SOFT;
        else if (uv)    return ST_UVLO;
        else if (!f_hi) return ST_SHUTDOWN;
        else if (!s_hi) return ST_FREEZE;
        else            return ST_NORMAL;
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_NORMAL:   st_d = open_pick(soft_req, uv_vcc, fault_line_hi, sync_line_hi);
            ST_FREEZE:   st_d = open_pick(soft_req, uv_vcc, fault_line_hi, sync_line_hi);
            ST_SHUTDOWN: st_d = open_pick(soft_req, uv_vcc, fault_line_hi, sync_line_hi);
            ST_UVLO:     st_d = open_pick(soft_req, uv_vcc, fault_line_hi, sync_line_hi);
            ST_SOFT:     if (!soft_req) st_d = ST_LATCH;
            ST_LATCH:    if (clr_ok)    st_d = ST_SHUTDOWN;
            default:     st_d = ST_LATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_NORMAL;
        else        st_q <= st_d;
    end

    always_comb begin
        drv = '0;
        unique case (st_q)
            ST_NORMAL:   drv = '0;
            ST_FREEZE:   drv.freeze = 1'b1;
            ST_SHUTDOWN: drv.hard_shdn = 1'b1;
            ST_UVLO: begin
                drv.fault_pd  = 1'b1;
                drv.hard_shdn = 1'b1;
            end
            ST_SOFT: begin
                drv.sync_pd = 1'b1;
                drv.freeze  = 1'b1;
            end
            ST_LATCH: begin
                drv.fault_pd  = 1'b1;
                drv.hard_shdn = 1'b1;
            end
            default: begin
                drv.fault_pd  = 1'b1;
                drv.hard_shdn = 1'b1;
            end
        endcase
    end

    assign state = st_q;

    // R2
    soft_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SOFT && ssd_any) |=> (st_q == ST_SOFT));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH && !flt_clr) |=> (st_q == ST_LATCH));

    // R4
    clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH && !sync_line_hi) |=> drv.fault_pd);

    // R7
    freeze_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv.freeze && drv.hard_shdn));

endmodule

// File: rtl/pfm_hs_gate.sv
module pfm_hs_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_vbs,
    input  logic hin,
    output logic hs_off
);

    logic hin_q;
    logic lock_q;
    logic hin_rise;

    assign hin_rise = hin & ~hin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hin_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            hin_q <= hin;
            if (uv_vbs)                lock_q <= 1'b1;
            else if (lock_q && hin_rise) lock_q <= 1'b0;
        end
    end

    assign hs_off = lock_q;

    // R9
    vbs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_vbs |=> hs_off);

    // R10
    vbs_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_off) |-> ($past(hin) && !$past(uv_vbs)));

endmodule

// File: rtl/phase_fault_mgr.sv
module phase_fault_mgr
    import pfm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = PFM_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic desat_hi_req,
    input  logic desat_lo_req,
    input  logic ssd_hi_act,
    input  logic ssd_lo_act,
    input  logic uv_vcc,
    input  logic uv_vbs,
    input  logic flt_clr,
    input  logic hin,
    input  logic fault_line_in,
    input  logic sync_line_in,
    output logic fault_line_pd,
    output logic sync_line_pd,
    output logic hard_shdn,
    output logic freeze,
    output logic hs_off
);

    logic       fault_hi;
    logic       sync_hi;
    logic       desat_any;
    logic       ssd_any;
    pfm_state_e state;
    pfm_drive_t drv;

    assign desat_any = desat_hi_req | desat_lo_req;
    assign ssd_any   = ssd_hi_act | ssd_lo_act;

    pfm_line_sync #(.STAGES(SYNC_STAGES)) u_fault_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (fault_line_in),
        .line_hi  (fault_hi)
    );

    pfm_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (sync_line_in),
        .line_hi  (sync_hi)
    );

    pfm_fault_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .desat_any     (desat_any),
        .ssd_any       (ssd_any),
        .uv_vcc        (uv_vcc),
        .flt_clr       (flt_clr),
        .fault_line_hi (fault_hi),
        .sync_line_hi  (sync_hi),
        .state         (state),
        .drv           (drv)
    );

    pfm_hs_gate u_hs_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .uv_vbs (uv_vbs),
        .hin    (hin),
        .hs_off (hs_off)
    );

    assign fault_line_pd = drv.fault_pd;
    assign sync_line_pd  = drv.sync_pd;
    assign hard_shdn     = drv.hard_shdn;
    assign freeze        = drv.freeze;

    // R5
    uv_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_vcc && !desat_any && !ssd_any && state != ST_SOFT) |=> fault_line_pd);

    // R1
    soft_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ssd_any && state != ST_LATCH) |=> sync_line_pd);

endmodule

// File: tb/phase_fault_mgr_bench.sv
module phase_fault_mgr_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desat_hi_req = 0, desat_lo_req = 0, ssd_hi_act = 0, ssd_lo_act = 0;
    logic uv_vcc = 0, uv_vbs = 0, flt_clr = 0, hin = 0;
    logic ext_f = 0, ext_s = 0;
    logic fault_line_in, sync_line_in;
    logic fault_line_pd, sync_line_pd, hard_shdn, freeze, hs_off;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign fault_line_in = !(fault_line_pd || ext_f);
    assign sync_line_in  = !(sync_line_pd || ext_s);

    phase_fault_mgr u_phase_fault_mgr (
        .clk(clk), .rst_n(rst_n),
        .desat_hi_req(desat_hi_req), .desat_lo_req(desat_lo_req),
        .ssd_hi_act(ssd_hi_act), .ssd_lo_act(ssd_lo_act),
        .uv_vcc(uv_vcc), .uv_vbs(uv_vbs), .flt_clr(flt_clr), .hin(hin),
        .fault_line_in(fault_line_in), .sync_line_in(sync_line_in),
        .fault_line_pd(fault_line_pd), .sync_line_pd(sync_line_pd),
        .hard_shdn(hard_shdn), .freeze(freeze), .hs_off(hs_off)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic clear_fault();
        flt_clr = 1'b1;
        tick(1);
        flt_clr = 1'b0;
        tick(5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        chk("R11 fault_pd", fault_line_pd, 1'b0);
        chk("R11 sync_pd", sync_line_pd, 1'b0);
        chk("R11 hard", hard_shdn, 1'b0);
        chk("R11 freeze", freeze, 1'b0);
        chk("R11 hs_off", hs_off, 1'b0);

        // R1 high-side desat enters soft shutdown
        desat_hi_req = 1; ssd_hi_act = 1;
        tick(1);
        chk("R1 sync_pd", sync_line_pd, 1'b1);
        chk("R1 freeze", freeze, 1'b1);
        chk("R1 hard", hard_shdn, 1'b0);
        chk("R1 fault_pd", fault_line_pd, 1'b0);
        // R2 masking of undervoltage and external shutdown
        desat_hi_req = 0; uv_vcc = 1; ext_f = 1;
        tick(4);
        chk("R2 sync_pd", sync_line_pd, 1'b1);
        chk("R2 hard", hard_shdn, 1'b0);
        chk("R2 fault_pd", fault_line_pd, 1'b0);
        // R3 end of soft shutdown latches
        ssd_hi_act = 0;
        tick(1);
        chk("R3 fault_pd", fault_line_pd, 1'b1);
        chk("R3 hard", hard_shdn, 1'b1);
        chk("R3 sync_pd", sync_line_pd, 1'b0);
        uv_vcc = 0; ext_f = 0;
        // R4 clear ignored while sync line low
        ext_s = 1;
        tick(4);
        flt_clr = 1;
        tick(1);
        flt_clr = 0;
        chk("R4 clear blocked", fault_line_pd, 1'b1);
        tick(2);
        chk("R3 latch held", fault_line_pd, 1'b1);
        ext_s = 0;
        tick(3);
        flt_clr = 1;
        tick(1);
        flt_clr = 0;
        chk("R4 fault_pd released", fault_line_pd, 1'b0);
        chk("R4 hard kept", hard_shdn, 1'b1);
        tick(2);
        chk("R4 hard at edge 3-1", hard_shdn, 1'b1);
        tick(1);
        chk("R4 hard released", hard_shdn, 1'b0);

        // R7 freeze from peer
        ext_s = 1;
        tick(2);
        chk("R7 freeze not yet", freeze, 1'b0);
        tick(1);
        chk("R7 freeze", freeze, 1'b1);
        chk("R7 hard", hard_shdn, 1'b0);
        // R8 low-side desat during freeze
        desat_lo_req = 1; ssd_lo_act = 1;
        tick(1);
        chk("R8 sync_pd", sync_line_pd, 1'b1);
        chk("R8 hard", hard_shdn, 1'b0);
        desat_lo_req = 0; ssd_lo_act = 0;
        tick(1);
        chk("R3 low-side latch", fault_line_pd, 1'b1);
        ext_s = 0;
        tick(3);
        clear_fault();
        chk("R4 back to normal", hard_shdn, 1'b0);

        // R8 desat during undervoltage
        uv_vcc = 1;
        tick(2);
        desat_hi_req = 1;
        tick(1);
        chk("R8 uv->soft", sync_line_pd, 1'b1);
        desat_hi_req = 0; uv_vcc = 0;
        tick(1);
        chk("R8 latched after", fault_line_pd, 1'b1);
        tick(3);
        clear_fault();

        // R6 external shutdown
        ext_f = 1;
        tick(2);
        chk("R6 hard not yet", hard_shdn, 1'b0);
        tick(1);
        chk("R6 hard", hard_shdn, 1'b1);
        chk("R6 fault_pd", fault_line_pd, 1'b0);
        flt_clr = 1;
        tick(2);
        flt_clr = 0;
        chk("R6 clear no effect", hard_shdn, 1'b1);
        ext_f = 0;
        tick(2);
        chk("R6 hard still", hard_shdn, 1'b1);
        tick(1);
        chk("R6 released", hard_shdn, 1'b0);

        // R5 logic-supply undervoltage
        uv_vcc = 1;
        tick(1);
        chk("R5 fault_pd", fault_line_pd, 1'b1);
        chk("R5 hard", hard_shdn, 1'b1);
        tick(3);
        chk("R5 held", fault_line_pd, 1'b1);
        uv_vcc = 0;
        tick(1);
        chk("R5 not latched", fault_line_pd, 1'b0);
        chk("R5 hard kept", hard_shdn, 1'b1);
        tick(2);
        chk("R5 hard edge 3-1", hard_shdn, 1'b1);
        tick(1);
        chk("R5 hard released", hard_shdn, 1'b0);

        // R7 sweep of open-state causes with priority
        for (int c = 0; c < 8; c++) begin
            logic e_f, e_h, e_z;
            uv_vcc = c[0]; ext_f = c[1]; ext_s = c[2];
            tick(4);
            e_f = c[0];
            e_h = c[0] | c[1];
            e_z = !c[0] && !c[1] && c[2];
            chk($sformatf("R7 sweep %0d fault_pd", c), fault_line_pd, e_f);
            chk($sformatf("R7 sweep %0d hard", c), hard_shdn, e_h);
            chk($sformatf("R7 sweep %0d freeze", c), freeze, e_z);
            uv_vcc = 0; ext_f = 0; ext_s = 0;
            tick(6);
        end

        // R9 floating-supply undervoltage
        hin = 1;
        tick(1);
        uv_vbs = 1;
        tick(1);
        chk("R9 hs_off", hs_off, 1'b1);
        chk("R9 no diag", fault_line_pd, 1'b0);
        chk("R9 no hard", hard_shdn, 1'b0);
        chk("R9 no sync", sync_line_pd, 1'b0);
        // R10 re-arm needs fresh rising edge
        uv_vbs = 0;
        tick(3);
        chk("R10 held with hin high", hs_off, 1'b1);
        hin = 0;
        tick(1);
        chk("R10 held hin low", hs_off, 1'b1);
        hin = 1;
        tick(1);
        chk("R10 released", hs_off, 1'b0);
        uv_vbs = 1; hin = 0;
        tick(1);
        hin = 1;
        tick(1);
        chk("R10 rise during uv", hs_off, 1'b1);
        uv_vbs = 0;
        tick(1);
        chk("R10 no stale rise", hs_off, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule